// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits behind a serial-peripheral slave front end that has already turned the incoming bit stream into whole bytes. It recognises each instruction frame, gathers the address that follows an addressed opcode, and turns the frame into requests on a small synchronous memory port. Read and identification frames stream bytes back to the front end for as long as chip select stays low. Program and erase frames are committed only when chip select is released after a complete frame. Each committed write starts a busy interval whose length is set by a parameter.

Frames are delimited by the active-low `cs_n` level, sampled in the `clk` domain. The front end raises `bit_pend` in the cycle in which `cs_n` goes high if it still holds an incomplete byte. Received bytes arrive as single-cycle `rx_valid` strobes. The input has no back-pressure, because the serial link cannot be stalled. The outgoing stream uses valid/ready. `tx_valid` is raised with `tx_data` and both hold unchanged until a cycle with `tx_ready` high, and the next byte follows a few cycles later. Memory read data must appear on `mem_rdata` in the cycle after a read request. Write permission (`wel`) and the protection decision (`prot_hit` for the address on `prot_addr`, and `any_prot`) come from a separate status block. This block reports `busy`, `aai_on` and a one-cycle `wel_clr` to that status block.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `aai_on`, `tx_valid`, `mem_req` and `wel_clr` are 0.
- R2: A frame of opcode 03h followed by three address bytes (most significant byte first) streams memory bytes from the address, then address+1 and so on. Only the low ADDR_W address bits are used. Each byte is fetched with `mem_req`=1 and `mem_op`=0, and the data is taken from `mem_rdata` one cycle later.
- R3: A read stream that passes the top address (all ones) continues from address 0.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` stay unchanged. One cycle after `cs_n` is high, `tx_valid` is 0.
- R5: Opcode 90h or ABh with three address bytes streams the identity bytes. MFR_ID (default BFh) is sent for an even address and DEV_ID (default 80h) for an odd one. The stream starts from the byte that A0 selects and then alternates without end.
- R6: A frame of exactly 02h, three address bytes and one data byte, closed with `bit_pend`=0, makes one request with `mem_op`=1 at that address with that data. `busy` is then high for T_PROG cycles, and `wel_clr` pulses once in the last busy cycle.
- R7: A write frame is discarded if `bit_pend` is 1 when `cs_n` rises, or if the frame does not have exactly the byte count its opcode needs.
- R8: Program, erase and auto-increment frames are ignored when `wel` is 0 or `prot_hit` is 1 for the target. Chip erase (60h, one byte) is ignored when `any_prot` is 1.
- R9: Sector erase (20h) requests `mem_op`=2 at the address with its low SEC_W bits cleared and sets busy for T_SE cycles. Block erase (52h) requests `mem_op`=3 with the low BLK_W bits cleared and sets busy for T_BE cycles. Chip erase requests `mem_op`=4 and sets busy for T_CE cycles. Each of these pulses `wel_clr` at its end.
- R10: AFh with three address bytes and one data byte programs that address and sets `aai_on`. While `aai_on` is set, a frame of AFh plus one data byte programs the next sequential address, and frames for 02h, 20h, 52h and 60h are ignored. These auto-increment writes do not pulse `wel_clr` when they finish.
- R11: Auto-increment mode ends, with one `wel_clr` pulse, right after a write to the top address or a write whose next address is protected. A one-byte 04h frame also ends it.
- R12: Any frame whose opcode byte arrives while `busy` is high produces no memory request and no output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select level |
| bit_pend | input | 1 | Incomplete byte held at frame end |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Front end takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| wel | input | 1 | Write-enable latch from status block |
| prot_hit | input | 1 | `prot_addr` lies in a protected region |
| any_prot | input | 1 | Some region is protected |
| prot_addr | output | ADDR_W | Address under protection check |
| busy | output | 1 | Self-timed write or erase in progress |
| aai_on | output | 1 | Auto-increment programming active |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| mem_req | output | 1 | Memory request strobe |
| mem_op | output | 3 | 0 read, 1 program, 2 sector, 3 block, 4 chip |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Program data |
| mem_rdata | input | 8 | Read data, one cycle after request |

## Verification
The bench builds the block with ADDR_W=12, SEC_W=8 and BLK_W=10. This makes the 4 KB address space small enough that read wrap-around and the top-address exit from auto-increment mode are reached with only a few bytes, and it keeps the erase alignment masks easy to see. The busy times are 20, 30, 40 and 50 cycles. That length is enough for a complete frame to start inside a busy window, so discard on busy can be tested. The four busy lengths also differ, so each write kind can be told apart by its measured interval.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    MOP_READ = 3'd0,
    MOP_PROG = 3'd1,
    MOP_SEC  = 3'd2,
    MOP_BLK  = 3'd3,
    MOP_CHIP = 3'd4
  } mem_op_e;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_AAI  = 8'hAF;
  localparam logic [7:0] OPC_SEC  = 8'h20;
  localparam logic [7:0] OPC_BLK  = 8'h52;
  localparam logic [7:0] OPC_CHIP = 8'h60;
  localparam logic [7:0] OPC_ID0  = 8'h90;
  localparam logic [7:0] OPC_ID1  = 8'hAB;
  localparam logic [7:0] OPC_WDIS = 8'h04;
endpackage

// File: rtl/sfc_frame.sv
module sfc_frame #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              bit_pend,
  input  logic              busy,
  output logic              frm_done,
  output logic [2:0]        frm_cnt,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        last_byte,
  output logic              dropped,
  output logic              addr_done
);
  logic cs_q;
  logic frm_end;

  // frame closes on the low-to-high step of the select level
  assign frm_end  = cs_n & ~cs_q;
  assign frm_done = frm_end & ~bit_pend & ~dropped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      frm_cnt   <= '0;
      opcode    <= '0;
      addr      <= '0;
      last_byte <= '0;
      dropped   <= 1'b0;
      addr_done <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      addr_done <= rx_valid && !cs_n && (frm_cnt == 3'd3);
      if (cs_n) begin
        frm_cnt <= '0;
      end else if (rx_valid) begin
        frm_cnt   <= (frm_cnt == 3'd7) ? frm_cnt : frm_cnt + 3'd1;
        last_byte <= rx_data;
        if (frm_cnt == 3'd0) begin
          opcode  <= rx_data;
          dropped <= busy;
        end
        if (frm_cnt >= 3'd1 && frm_cnt <= 3'd3)
          addr <= {addr[ADDR_W-9:0], rx_data};
      end
    end
  end
endmodule

// File: rtl/sfc_busy.sv
module sfc_busy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             clr_req,
  output logic             busy,
  output logic             done_clr
);
  logic [CNT_W-1:0] tmr;
  logic             pend;

  assign busy     = (tmr != '0);
  assign done_clr = (tmr == CNT_W'(1)) & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= '0;
      pend <= 1'b0;
    end else if (start) begin
      tmr  <= load;
      pend <= clr_req;
    end else if (tmr != '0) begin
      tmr <= tmr - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sfc_rdstream.sv
module sfc_rdstream #(
  parameter int          ADDR_W = 20,
  parameter logic [7:0]  MFR_ID = 8'hBF,
  parameter logic [7:0]  DEV_ID = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              is_id,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop,
  input  logic              tx_ready,
  input  logic [7:0]        mem_rdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_HOLD} st_e;
  st_e  st;
  logic id_q;

  assign rd_req = (st == S_FETCH) && !id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      id_q     <= 1'b0;
      rd_addr  <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (stop) begin
      st       <= S_IDLE;
      tx_valid <= 1'b0;
    end else if (go) begin
      st      <= S_FETCH;
      id_q    <= is_id;
      rd_addr <= start_addr;
    end else begin
      case (st)
        S_FETCH: begin
          if (id_q) begin
            tx_data  <= rd_addr[0] ? DEV_ID : MFR_ID;
            tx_valid <= 1'b1;
            st       <= S_HOLD;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          tx_data  <= mem_rdata;
          tx_valid <= 1'b1;
          st       <= S_HOLD;
        end
        S_HOLD: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            rd_addr  <= rd_addr + ADDR_W'(1);
            st       <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq #(
  parameter int         ADDR_W = 20,
  parameter int         SEC_W  = 12,
  parameter int         BLK_W  = 15,
  parameter int         T_PROG = 16,
  parameter int         T_SE   = 64,
  parameter int         T_BE   = 128,
  parameter int         T_CE   = 256,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_pend,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              wel,
  input  logic              prot_hit,
  input  logic              any_prot,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              busy,
  output logic              aai_on,
  output logic              wel_clr,
  output logic              mem_req,
  output logic [2:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import sfc_pkg::*;

  localparam int T_A   = (T_PROG > T_SE) ? T_PROG : T_SE;
  localparam int T_B   = (T_BE > T_CE) ? T_BE : T_CE;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic              frm_done, dropped, addr_done;
  logic [2:0]        frm_cnt;
  logic [7:0]        opcode, last_byte;
  logic [ADDR_W-1:0] f_addr;

  sfc_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .bit_pend(bit_pend), .busy(busy),
    .frm_done(frm_done), .frm_cnt(frm_cnt), .opcode(opcode),
    .addr(f_addr), .last_byte(last_byte), .dropped(dropped),
    .addr_done(addr_done)
  );

  // auto-increment tracking
  logic [ADDR_W-1:0] aai_addr;
  logic              aai_top, aai_chk, aai_end;

  assign prot_addr = aai_on ? aai_addr : f_addr;

  // commit decode at a clean frame end
  logic wr_ok, c_prog, c_aai1, c_aain, c_sec, c_blk, c_chip, c_wdis, c_any;
  assign wr_ok  = wel & ~prot_hit;
  assign c_prog = frm_done && opcode == OPC_PROG && frm_cnt == 3'd5 && !aai_on && wr_ok;
  assign c_aai1 = frm_done && opcode == OPC_AAI  && frm_cnt == 3'd5 && !aai_on && wr_ok;
  assign c_aain = frm_done && opcode == OPC_AAI  && frm_cnt == 3'd2 &&  aai_on && wr_ok;
  assign c_sec  = frm_done && opcode == OPC_SEC  && frm_cnt == 3'd4 && !aai_on && wr_ok;
  assign c_blk  = frm_done && opcode == OPC_BLK  && frm_cnt == 3'd4 && !aai_on && wr_ok;
  assign c_chip = frm_done && opcode == OPC_CHIP && frm_cnt == 3'd1 && !aai_on && wel && !any_prot;
  assign c_wdis = frm_done && opcode == OPC_WDIS && frm_cnt == 3'd1;
  assign c_any  = c_prog | c_aai1 | c_aain | c_sec | c_blk | c_chip;

  logic [ADDR_W-1:0] sec_base, blk_base, aai_tgt;
  assign sec_base = {f_addr[ADDR_W-1:SEC_W], {SEC_W{1'b0}}};
  assign blk_base = {f_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
  assign aai_tgt  = c_aai1 ? f_addr : aai_addr;

  mem_op_e           w_op, wr_op_q;
  logic [CNT_W-1:0]  w_time;
  logic [ADDR_W-1:0] w_addr, wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              wr_req_q;

  always_comb begin
    w_op   = MOP_PROG;
    w_time = CNT_W'(T_PROG);
    w_addr = c_aain ? aai_addr : f_addr;
    if (c_sec) begin
      w_op = MOP_SEC;  w_time = CNT_W'(T_SE); w_addr = sec_base;
    end else if (c_blk) begin
      w_op = MOP_BLK;  w_time = CNT_W'(T_BE); w_addr = blk_base;
    end else if (c_chip) begin
      w_op = MOP_CHIP; w_time = CNT_W'(T_CE); w_addr = '0;
    end
  end

  logic done_clr;
  sfc_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(c_any), .load(w_time),
    .clr_req(c_prog | c_sec | c_blk | c_chip),
    .busy(busy), .done_clr(done_clr)
  );

  assign aai_end = aai_chk && (aai_top || prot_hit);
  assign wel_clr = aai_end | done_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aai_on    <= 1'b0;
      aai_addr  <= '0;
      aai_top   <= 1'b0;
      aai_chk   <= 1'b0;
      wr_req_q  <= 1'b0;
      wr_op_q   <= MOP_READ;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_req_q <= c_any;
      if (c_any) begin
        wr_op_q   <= w_op;
        wr_addr_q <= w_addr;
        wr_data_q <= last_byte;
      end
      aai_chk <= c_aai1 | c_aain;
      if (c_aai1 | c_aain) begin
        aai_on   <= 1'b1;
        aai_addr <= aai_tgt + ADDR_W'(1);
        aai_top  <= (aai_tgt == {ADDR_W{1'b1}});
      end else if (aai_end || c_wdis) begin
        aai_on <= 1'b0;
      end
    end
  end

  // read and identification streaming
  logic              rd_go, rd_req;
  logic [ADDR_W-1:0] rd_addr;
  assign rd_go = addr_done && !dropped &&
                 (opcode == OPC_READ || opcode == OPC_ID0 || opcode == OPC_ID1);

  sfc_rdstream #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .is_id(opcode != OPC_READ),
    .start_addr(f_addr), .stop(cs_n), .tx_ready(tx_ready),
    .mem_rdata(mem_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign mem_req   = wr_req_q | rd_req;
  assign mem_op    = wr_req_q ? wr_op_q : MOP_READ;
  assign mem_addr  = wr_req_q ? wr_addr_q : rd_addr;
  assign mem_wdata = wr_data_q;
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int ADDR_W = 20,
  parameter int SEC_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              busy,
  input logic              wel,
  input logic              wel_clr,
  input logic              mem_req,
  input logic [2:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr
);
  logic wr_req;
  assign wr_req = mem_req && (mem_op != 3'd0);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cs_n) |=> (tx_valid && $stable(tx_data)));
  // R4
  tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !tx_valid);
  // R6
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_req);
  // R8
  wr_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(wel));
  // R9
  sec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_op == 3'd2) |-> (mem_addr[SEC_W-1:0] == '0));
  // R11
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
  // R12
  busy_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !wr_req);
endmodule

bind sflash_cmd_seq sfc_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .busy(busy), .wel(wel),
  .wel_clr(wel_clr), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr)
);

// File: tb/sflash_cmd_seq_tb_top.sv
module sflash_cmd_seq_tb_top;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, bit_pend = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic wel = 1'b1;
  int   prot_base = 4096;
  logic tx_valid, busy, aai_on, wel_clr, mem_req, prot_hit, any_prot;
  logic [7:0] tx_data, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [2:0] mem_op;
  logic [AW-1:0] prot_addr, mem_addr;

  int n_run = 0, n_fail = 0;
  int n_wr = 0, n_busy = 0, n_clr = 0;
  int l_op = 0, l_addr = 0, l_data = 0;

  always #4 clk = ~clk;

  assign prot_hit = (int'(prot_addr) >= prot_base);
  assign any_prot = (prot_base < 4096);

  sflash_cmd_seq #(.ADDR_W(AW), .SEC_W(8), .BLK_W(10), .T_PROG(20),
                   .T_SE(30), .T_BE(40), .T_CE(50)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_pend(bit_pend),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .wel(wel), .prot_hit(prot_hit),
    .any_prot(any_prot), .prot_addr(prot_addr), .busy(busy), .aai_on(aai_on),
    .wel_clr(wel_clr), .mem_req(mem_req), .mem_op(mem_op),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], 4'h6};
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_op == 3'd0) mem_rdata <= pat(mem_addr);
    if (mem_req && mem_op != 3'd0) begin
      n_wr   <= n_wr + 1;
      l_op   <= int'(mem_op);
      l_addr <= int'(mem_addr);
      l_data <= int'(mem_wdata);
    end
    if (busy) n_busy <= n_busy + 1;
    if (wel_clr) n_clr <= n_clr + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic cs_hi(input logic pend);
    @(negedge clk); cs_n = 1'b1; bit_pend = pend;
    @(negedge clk); bit_pend = 1'b0;
  endtask

  task automatic frame(input logic [7:0] op, input logic [23:0] a,
                       input logic [7:0] d, input int n, input logic pend);
    cs_lo();
    send(op);
    if (n >= 2 && n != 2) begin
      send(a[23:16]); send(a[15:8]); send(a[7:0]);
      if (n >= 5) send(d);
      if (n >= 6) send(8'h00);
    end else if (n == 2) begin
      send(d);
    end
    cs_hi(pend);
  endtask

  task automatic get_byte(input string tag, output logic [7:0] b);
    int t = 0;
    b = 8'h00;
    while (!tx_valid && t < 40) begin @(negedge clk); t++; end
    chk({tag, " tx_valid"}, int'(tx_valid), 1);
    b = tx_data;
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  // op, address, byte count
  localparam logic [39:0] VEC [5] = '{
    {8'h03, 24'h000123, 8'd4},
    {8'h03, 24'h000FFE, 8'd4},
    {8'h03, 24'hF5A7F0, 8'd3},
    {8'h90, 24'h000000, 8'd4},
    {8'hAB, 24'h000001, 8'd3}
  };

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b, b0;
    int w0, c0, bz0;
    idle(3); rst_n = 1'b1; @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 aai_on", int'(aai_on), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 wel_clr", int'(wel_clr), 0);

    // R2 R3 R5 table of read and identification streams
    for (int v = 0; v < 5; v++) begin
      logic [7:0] op; logic [23:0] a; int nb;
      op = VEC[v][39:32]; a = VEC[v][31:8]; nb = int'(VEC[v][7:0]);
      cs_lo(); send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < nb; i++) begin
        logic [7:0] e;
        logic [AW-1:0] ai;
        ai = a[AW-1:0] + AW'(i);
        if (op == 8'h03) e = pat(ai);
        else e = (a[0] ^ i[0]) ? 8'h80 : 8'hBF;
        get_byte(op == 8'h03 ? "R2/R3 read" : "R5 id", b);
        chk(op == 8'h03 ? "R2/R3 read data" : "R5 id data", int'(b), int'(e));
      end
      cs_hi(1'b0);
    end

    // R4 hold without ready, then drop on frame end
    cs_lo(); send(8'h03); send(8'h00); send(8'h00); send(8'h50);
    idle(6);
    b0 = tx_data;
    chk("R4 valid up", int'(tx_valid), 1);
    idle(5);
    chk("R4 valid held", int'(tx_valid), 1);
    chk("R4 data held", int'(tx_data), int'(b0));
    cs_hi(1'b0);
    chk("R4 valid cleared", int'(tx_valid), 0);

    // R6 byte program
    w0 = n_wr; c0 = n_clr; bz0 = n_busy;
    frame(8'h02, 24'h000123, 8'h5A, 5, 1'b0);
    idle(60);
    chk("R6 writes", n_wr - w0, 1);
    chk("R6 op", l_op, 1);
    chk("R6 addr", l_addr, 'h123);
    chk("R6 data", l_data, 'h5A);
    chk("R6 busy len", n_busy - bz0, 20);
    chk("R6 wel_clr", n_clr - c0, 1);

    // R7 abort cases
    w0 = n_wr;
    frame(8'h02, 24'h000124, 8'h11, 5, 1'b1);
    frame(8'h02, 24'h000125, 8'h11, 4, 1'b0);
    frame(8'h02, 24'h000126, 8'h11, 6, 1'b0);
    idle(5);
    chk("R7 aborted writes", n_wr - w0, 0);

    // R8 permission and protection gating
    w0 = n_wr;
    wel = 1'b0; frame(8'h02, 24'h000127, 8'h11, 5, 1'b0); wel = 1'b1;
    prot_base = 'h800;
    frame(8'h02, 24'h000900, 8'h11, 5, 1'b0);
    frame(8'h60, 24'h0, 8'h0, 1, 1'b0);
    prot_base = 4096;
    idle(5);
    chk("R8 gated writes", n_wr - w0, 0);

    // R9 erases
    bz0 = n_busy; c0 = n_clr;
    frame(8'h20, 24'h0003C5, 8'h0, 4, 1'b0); idle(60);
    chk("R9 sector op", l_op, 2);
    chk("R9 sector addr", l_addr, 'h300);
    chk("R9 sector busy", n_busy - bz0, 30);
    bz0 = n_busy;
    frame(8'h52, 24'h0007C5, 8'h0, 4, 1'b0); idle(60);
    chk("R9 block op", l_op, 3);
    chk("R9 block addr", l_addr, 'h400);
    chk("R9 block busy", n_busy - bz0, 40);
    bz0 = n_busy;
    frame(8'h60, 24'h0, 8'h0, 1, 1'b0); idle(70);
    chk("R9 chip op", l_op, 4);
    chk("R9 chip busy", n_busy - bz0, 50);
    chk("R9 wel_clr count", n_clr - c0, 3);

    // R10 auto-increment programming
    c0 = n_clr;
    frame(8'hAF, 24'h000100, 8'h11, 5, 1'b0); idle(3);
    chk("R10 first addr", l_addr, 'h100);
    chk("R10 aai_on", int'(aai_on), 1);
    idle(30);
    frame(8'hAF, 24'h0, 8'h22, 2, 1'b0); idle(3);
    chk("R10 next addr", l_addr, 'h101);
    chk("R10 next data", l_data, 'h22);
    idle(30);
    w0 = n_wr;
    frame(8'h02, 24'h000300, 8'h33, 5, 1'b0); idle(3);
    chk("R10 program ignored", n_wr - w0, 0);
    chk("R10 no wel_clr", n_clr - c0, 0);
    frame(8'h04, 24'h0, 8'h0, 1, 1'b0); idle(2);
    chk("R11 disable ends", int'(aai_on), 0);

    // R11 end at top address
    c0 = n_clr;
    frame(8'hAF, 24'h000FFE, 8'h44, 5, 1'b0); idle(30);
    chk("R11 still on", int'(aai_on), 1);
    frame(8'hAF, 24'h0, 8'h45, 2, 1'b0); idle(3);
    chk("R11 top addr", l_addr, 'hFFF);
    chk("R11 top exit", int'(aai_on), 0);
    chk("R11 top wel_clr", n_clr - c0, 1);
    idle(30);

    // R11 end before protected region
    prot_base = 'h800; c0 = n_clr;
    frame(8'hAF, 24'h0007FE, 8'h55, 5, 1'b0); idle(30);
    chk("R11 on below", int'(aai_on), 1);
    frame(8'hAF, 24'h0, 8'h56, 2, 1'b0); idle(3);
    chk("R11 last addr", l_addr, 'h7FF);
    chk("R11 prot exit", int'(aai_on), 0);
    chk("R11 prot wel_clr", n_clr - c0, 1);
    prot_base = 4096;
    idle(30);

    // R12 frames during busy are discarded
    w0 = n_wr;
    frame(8'h60, 24'h0, 8'h0, 1, 1'b0);
    frame(8'h02, 24'h000200, 8'h66, 5, 1'b0);
    idle(60);
    chk("R12 write discarded", n_wr - w0, 1);
    frame(8'h02, 24'h000200, 8'h66, 5, 1'b0);
    cs_lo(); send(8'h03); send(8'h00); send(8'h00); send(8'h10);
    b = 8'h0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_valid) b = 8'h1;
    end
    cs_hi(1'b0);
    chk("R12 read discarded", int'(b), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule